// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block moves the bits of a data word by a variable distance in a single pass of combinational logic. A 3-bit operation code selects one of six behaviours: two plain shifts, two arithmetic shifts and two rotations. A log2(W)-bit amount sets the distance. The word width W is a parameter, 8 by default, and must be a power of two.

The datapath is a cascade of log2(W) mux stages. Stage k moves the word by 2^k places when bit k of the amount is set and passes it through otherwise. Every stage uses the same cell network. The operation only changes the direction and the source of the bits that enter at the vacated end. Those bits can be zeros, copies of the original top bit, or the bits that fall off the other end.

An enable input forces the result to zero. Two spare operation codes pass the word through unchanged.

Top module: `bshift_top`

## Requirements
- R1: Operation code 3'b000 shifts left by the amount and fills the vacated low bits with 0.
- R2: Operation code 3'b001 shifts right by the amount and fills the vacated high bits with 0.
- R3: Operation code 3'b010 gives exactly the same result as code 3'b000 for every data word and amount.
- R4: Operation code 3'b011 shifts right by the amount and fills the vacated high bits with copies of data bit W-1.
- R5: Operation code 3'b100 rotates left. Bits leaving position W-1 re-enter at position 0, and the number of set bits is kept.
- R6: Operation code 3'b101 rotates right. Bits leaving position 0 re-enter at position W-1, and the number of set bits is kept.
- R7: Operation codes 3'b110 and 3'b111 return the data word unchanged for any amount.
- R8: An amount of 0 returns the data word unchanged for every operation code.
- R9: When enable is 0, the output is all zeros regardless of data, amount and operation.
- R10: Each amount bit k adds a move of exactly 2^k places, so any amount from 0 to W-1 gives the full distance in one pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Enable; 0 forces the output to zero |
| op_code | input | 3 | Operation select (encoding in R1 to R7) |
| amt | input | log2(W) | Shift or rotate distance |
| din | input | W | Data word |
| dout | output | W | Shifted or rotated word |

## Verification
The hardest case to reach is fill data that must stay correct while it passes through several stages. An arithmetic right shift by W-1 with the top bit set must copy the sign into every stage. A rotation by an amount with several bits set must wrap bits around at more than one stage. An arithmetic right shift by W-1 makes every stage take the sign fill at once. An amount with several bits set makes the wrapped bits of one stage feed the wrap of the next.

The bench sweeps every data word, every amount, every operation code and both enable values on the default 8-bit configuration. That sweep covers all these stacked-fill cases. The bench compares each result with shift, arithmetic-shift and concatenation-based rotate models.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        OP_SLL  = 3'b000,
        OP_SRL  = 3'b001,
        OP_SLA  = 3'b010,
        OP_SRA  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_NOP6 = 3'b110,
        OP_NOP7 = 3'b111
    } shop_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  active;
        logic  to_left;
        fill_e fill;
    } shctl_t;

    function automatic shctl_t decode_op(shop_e op);
        shctl_t c;
        c.active  = 1'b1;
        c.to_left = 1'b0;
        c.fill    = FILL_ZERO;
        case (op)
            OP_SLL, OP_SLA: c.to_left = 1'b1;
            OP_SRL:         c.to_left = 1'b0;
            OP_SRA:         c.fill    = FILL_SIGN;
            OP_ROL: begin
                c.to_left = 1'b1;
                c.fill    = FILL_WRAP;
            end
            OP_ROR:         c.fill    = FILL_WRAP;
            default:        c.active  = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
    import bshift_pkg::*;
(
    input  logic [2:0] op_code,
    output shctl_t     ctl
);

    always_comb begin
        ctl = decode_op(shop_e'(op_code));
    end

    // sign fill only ever travels rightwards; wrap/zero never idle modes
    always_comb begin
        if (ctl.fill == FILL_SIGN) begin
            AST_SIGN_FILL_RIGHT: assert (!ctl.to_left) else $error("sign fill on left move"); // R4
        end
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int W    = 8,
    parameter int STEP = 1
) (
    input  logic [W-1:0] stage_in,
    input  logic         take,
    input  shctl_t       ctl,
    input  logic         sign_bit,
    output logic [W-1:0] stage_out
);

    logic [W-1:0] from_low;   // candidate when moving left
    logic [W-1:0] from_high;  // candidate when moving right
    logic         wrap_on;
    logic         sign_on;

    assign wrap_on = (ctl.fill == FILL_WRAP);
    assign sign_on = (ctl.fill == FILL_SIGN);

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i >= STEP) begin : g_lo_in
            assign from_low[i] = stage_in[i-STEP];
        end else begin : g_lo_fill
            assign from_low[i] = wrap_on & stage_in[i-STEP+W];
        end

        if (i + STEP < W) begin : g_hi_in
            assign from_high[i] = stage_in[i+STEP];
        end else begin : g_hi_fill
            assign from_high[i] = wrap_on ? stage_in[i+STEP-W] : (sign_on & sign_bit);
        end

        assign stage_out[i] = !take ? stage_in[i] : (ctl.to_left ? from_low[i] : from_high[i]);
    end

    always_comb begin
        if (take && wrap_on) begin
            AST_STAGE_WRAP_KEEPS_ONES: assert ($countones(stage_out) == $countones(stage_in)) else $error("wrap stage lost bits"); // R5
        end
        if (take && ctl.to_left && !wrap_on) begin
            AST_STAGE_LEFT_ZERO_FILL: assert (stage_out[STEP-1:0] == '0) else $error("left fill not zero"); // R1
        end
    end

endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = $clog2(W)
) (
    input  logic          en,
    input  logic [2:0]    op_code,
    input  logic [AW-1:0] amt,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    localparam int NSTAGE = AW;

    shctl_t       ctl;
    logic [W-1:0] chain [0:NSTAGE];

    bshift_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    assign chain[0] = din;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        bshift_stage #(
            .W    (W),
            .STEP (1 << k)
        ) u_stg (
            .stage_in  (chain[k]),
            .take      (amt[k] & ctl.active),
            .ctl       (ctl),
            .sign_bit  (din[W-1]),
            .stage_out (chain[k+1])
        );
    end

    assign dout = en ? chain[NSTAGE] : '0;

    always_comb begin
        if (!en) begin
            AST_DISABLED_ZERO: assert (dout == '0) else $error("output live while disabled"); // R9
        end
        if (en && amt == '0) begin
            AST_ZERO_AMT_PASS: assert (dout == din) else $error("zero amount altered data"); // R8
        end
        if (en && (op_code == OP_ROL || op_code == OP_ROR)) begin
            AST_ROT_KEEPS_ONES: assert ($countones(dout) == $countones(din)) else $error("rotate changed popcount"); // R6
        end
        if (en && op_code == OP_SRA) begin
            AST_SRA_SIGN_KEPT: assert (dout[W-1] == din[W-1]) else $error("sign bit lost"); // R4
        end
        if (en && op_code == OP_SRL && amt != '0) begin
            AST_SRL_TOP_ZERO: assert (dout[W-1] == 1'b0) else $error("logical right top bit set"); // R2
        end
        if (en && op_code[2:1] == 2'b11) begin
            AST_SPARE_PASS: assert (dout == din) else $error("spare code altered data"); // R7
        end
    end

endmodule

// File: tb/sim_bshift_top.sv
module sim_bshift_top;

    localparam int W          = 8;
    localparam int AW         = $clog2(W);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          en;
    logic [2:0]    op_code;
    logic [AW-1:0] amt;
    logic [W-1:0]  din;
    logic [W-1:0]  dout;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bshift_top #(.W(W)) u0 (
        .en      (en),
        .op_code (op_code),
        .amt     (amt),
        .din     (din),
        .dout    (dout)
    );

    function automatic logic [W-1:0] model(logic e, logic [2:0] op, int a, logic [W-1:0] d);
        logic [2*W-1:0] dd;
        dd = {d, d};
        if (!e) return '0;
        case (op)
            3'b000, 3'b010: return d << a;
            3'b001:         return d >> a;
            3'b011:         return $signed(d) >>> a;
            3'b100: begin dd = dd << a; return dd[2*W-1:W]; end
            3'b101: begin dd = dd >> a; return dd[W-1:0]; end
            default:        return d;
        endcase
    endfunction

    function automatic string tag(logic e, logic [2:0] op, int a);
        if (!e)     return "R9";
        if (a == 0) return "R8";
        case (op)
            3'b000:  return "R1/R10";
            3'b001:  return "R2/R10";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: en=%0b op=%0b amt=%0d din=%b got %b expected %b",
                     req, en, op_code, amt, din, got, exp);
        end
    endtask

    initial begin
        // initial state check: disabled block drives zero (R9)
        en = 1'b0; op_code = 3'b000; amt = '0; din = 8'hA5;
        @(negedge clk); #1;
        check("R9", dout, '0);

        // hand-picked corner points
        en = 1'b1; op_code = 3'b011; amt = AW'(W-1); din = 8'h80;
        #1; check("R4", dout, 8'hFF);
        op_code = 3'b100; amt = 3'd5; din = 8'b1100_1001;
        #1; check("R5/R10", dout, 8'b0011_1001);
        op_code = 3'b101; amt = 3'd2; din = 8'b0001_1001;
        #1; check("R6", dout, 8'b0100_0110);

        for (int e = 0; e < 2; e++) begin
            for (int op = 0; op < 8; op++) begin
                for (int a = 0; a < W; a++) begin
                    for (int d = 0; d < (1 << W); d++) begin
                        @(negedge clk);
                        en      = e[0];
                        op_code = op[2:0];
                        amt     = a[AW-1:0];
                        din     = d[W-1:0];
                        #1;
                        check(tag(e[0], op[2:0], a), dout, model(e[0], op[2:0], a, d[W-1:0]));
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule